// File: doc/BRIEF.md
# Seconds Counter With Byte Register Access and Alarm

A 32-bit seconds counter behind a small 8-bit register bus (4-bit address, byte write data, write strobe, combinational read data). A prescaler turns the system clock into one count step every `TICK_DIV` cycles while the run bit is set. Software loads a new time through a separate load bank. The upper bytes only fill a shadow. The low byte, written last while the counter is stopped, commits the whole word in one cycle. The running value is read through its own read bank, and the live value lets software spot a carry by reading byte 0 a second time.

A four-byte alarm value is compared with the raw count. When a count step lands on the alarm value while the alarm is armed, a pending flag sets and the interrupt line rises once. The flag is cleared by writing zero to its bit.

Top module: `rtc_seconds`

## Requirements
- R1: After reset the count, the shadow, the alarm value, the run bit, the alarm-arm bit and the pending flag are all zero, and `alarmIrq` is low.
- R2: While bit 7 of register 0x0 is 1, the count rises by one every `TICK_DIV` clocks, with the first step `TICK_DIV` clocks after the write that set the bit. While that bit is 0 the count holds and the prescaler restarts from zero.
- R3: A step from 0xFFFFFFFF gives 0x00000000.
- R4: Writes to 0x5, 0x6 and 0x7 (count bytes 1, 2 and 3) go only to the shadow and leave the count unchanged. Reads of 0x4 to 0x7 return 0.
- R5: A write to 0x4 while the run bit is 0 loads the count with {shadow bytes 3..1, written byte} on that clock edge.
- R6: A write to 0x4 while the run bit is 1 has no effect on the count.
- R7: Reads of 0x8 to 0xB return count bytes 0 to 3 (little-endian, 0x8 least significant), live and without a latch.
- R8: Addresses 0xC to 0xF hold the alarm value bytes 0 to 3, little-endian, readable and writable.
- R9: Bit 7 of 0x0 and bit 7 of 0x1 (alarm arm) read back as written. Their other bits read 0.
- R10: Bit 0 of 0x2 (pending) sets on the clock edge where a step moves the count onto the alarm value while the alarm is armed. A load, or a step with the alarm unarmed, never sets it.
- R11: Writing 0x2 with bit 0 at 0 clears pending. Writing it with bit 0 at 1 leaves pending unchanged.
- R12: `alarmIrq` is high exactly when pending and alarm arm are both 1. It gives one rising edge per match and falls when the alarm is disarmed or pending is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one register write per cycle |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| alarmIrq | output | 1 | Alarm interrupt, level high, rising edge per match |

## Verification
The counter is loaded with an ordinary mid-range value, with all-ones so that a step has to carry across every byte, and with low values just below an alarm target. Running against stopped shows whether the prescaler and the run gating are correct. A low-byte write while running, against one while stopped, separates a correct commit gate from a free-running load. An alarm met with the arm bit set, an alarm passed with it clear, and a clear written with bit 0 at 1 against one at 0 separate the set, hold and clear paths of the pending flag and of the interrupt.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int NBYTES = 4;
  localparam int CNT_W = 8 * NBYTES;

  // address bank select = busAddr[3:2]
  localparam logic [1:0] BANK_CTRL = 2'd0;
  localparam logic [1:0] BANK_LOAD = 2'd1;
  localparam logic [1:0] BANK_READ = 2'd2;
  localparam logic [1:0] BANK_ALM  = 2'd3;

  // control bank offsets
  localparam logic [1:0] OFS_RUN  = 2'd0;
  localparam logic [1:0] OFS_ARM  = 2'd1;
  localparam logic [1:0] OFS_PEND = 2'd2;

  typedef struct packed {
    logic              runEn;
    logic              alarmArm;
    logic              commit;
    logic [NBYTES-1:1] shadowWe;
    logic [NBYTES-1:0] alarmWe;
    logic [7:0]        busByte;
  } dpCtl_t;
endpackage

// File: rtl/rtc_sec_datapath.sv
module rtc_sec_datapath
  import rtc_sec_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  output logic [CNT_W-1:0] countWord,
  output logic [CNT_W-1:0] alarmWord,
  output logic             matchHit
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic [7:0]       shadowB [NBYTES];
  logic [CNT_W-1:0] loadWord;

  assign tick = dpCtl.runEn && (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     preCnt <= '0;
    else if (!dpCtl.runEn || tick) preCnt <= '0;
    else                           preCnt <= preCnt + 1'b1;
  end

  assign shadowB[0] = dpCtl.busByte;

  genvar gi;
  generate
    for (gi = 1; gi < NBYTES; gi++) begin : g_shadow
      logic [7:0] hold;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  hold <= '0;
        else if (dpCtl.shadowWe[gi]) hold <= dpCtl.busByte;
      end
      assign shadowB[gi] = hold;
    end
    for (gi = 0; gi < NBYTES; gi++) begin : g_alarm
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  alarmWord[8*gi +: 8] <= '0;
        else if (dpCtl.alarmWe[gi]) alarmWord[8*gi +: 8] <= dpCtl.busByte;
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NBYTES; i++) loadWord[8*i +: 8] = shadowB[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             countWord <= '0;
    else if (dpCtl.commit) countWord <= loadWord;
    else if (tick)         countWord <= countWord + 1'b1;
  end

  assign matchHit = tick && dpCtl.alarmArm && ((countWord + 1'b1) == alarmWord);
endmodule

// File: rtl/rtc_sec_ctrl.sv
module rtc_sec_ctrl
  import rtc_sec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       busAddr,
  input  logic [7:0]       busWdata,
  input  logic             busWr,
  input  logic [CNT_W-1:0] countWord,
  input  logic [CNT_W-1:0] alarmWord,
  input  logic             matchHit,
  output dpCtl_t           dpCtl,
  output logic             pendFlag,
  output logic [7:0]       busRdata,
  output logic             alarmIrq
);
  logic       runBit;
  logic       armBit;
  logic [1:0] bank;
  logic [1:0] ofs;
  logic       ctrlWr;

  assign bank   = busAddr[3:2];
  assign ofs    = busAddr[1:0];
  assign ctrlWr = busWr && (bank == BANK_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      armBit   <= 1'b0;
      pendFlag <= 1'b0;
    end else begin
      if (ctrlWr && ofs == OFS_RUN) runBit <= busWdata[7];
      if (ctrlWr && ofs == OFS_ARM) armBit <= busWdata[7];
      if (matchHit)                                       pendFlag <= 1'b1;
      else if (ctrlWr && ofs == OFS_PEND && !busWdata[0]) pendFlag <= 1'b0;
    end
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.runEn    = runBit;
    dpCtl.alarmArm = armBit;
    dpCtl.busByte  = busWdata;
    dpCtl.commit   = busWr && (bank == BANK_LOAD) && (ofs == 2'd0) && !runBit;
    for (int i = 1; i < NBYTES; i++)
      dpCtl.shadowWe[i] = busWr && (bank == BANK_LOAD) && (ofs == 2'(i));
    for (int i = 0; i < NBYTES; i++)
      dpCtl.alarmWe[i] = busWr && (bank == BANK_ALM) && (ofs == 2'(i));
  end

  always_comb begin
    busRdata = '0;
    unique case (bank)
      BANK_CTRL: begin
        if (ofs == OFS_RUN)  busRdata = {runBit, 7'b0};
        if (ofs == OFS_ARM)  busRdata = {armBit, 7'b0};
        if (ofs == OFS_PEND) busRdata = {7'b0, pendFlag};
      end
      BANK_READ: busRdata = countWord[8*int'(ofs) +: 8];
      BANK_ALM:  busRdata = alarmWord[8*int'(ofs) +: 8];
      default:   busRdata = '0;
    endcase
  end

  assign alarmIrq = pendFlag && armBit;
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_sec_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWdata,
  input  logic       busWr,
  output logic [7:0] busRdata,
  output logic       alarmIrq
);
  dpCtl_t           dpCtl;
  logic [CNT_W-1:0] countWord;
  logic [CNT_W-1:0] alarmWord;
  logic             matchHit;
  logic             pendFlag;

  rtc_sec_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .countWord(countWord), .alarmWord(alarmWord), .matchHit(matchHit),
    .dpCtl(dpCtl), .pendFlag(pendFlag), .busRdata(busRdata), .alarmIrq(alarmIrq)
  );

  rtc_sec_datapath #(.TICK_DIV(TICK_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .countWord(countWord), .alarmWord(alarmWord), .matchHit(matchHit)
  );
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  busAddr,
  input logic [7:0]  busWdata,
  input logic        busWr,
  input logic [31:0] countWord,
  input logic        runEn,
  input logic        commit,
  input logic        alarmEn,
  input logic        matchHit,
  input logic        pendFlag,
  input logic        alarmIrq
);
  // R2
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !commit) |=> $stable(countWord));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> (countWord == $past(countWord)) || (countWord == $past(countWord) + 32'd1));

  // R5
  load_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> countWord[7:0] == $past(busWdata));

  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlag) |-> $past(matchHit));

  // R11
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'h2 && !busWdata[0] && !matchHit) |=> !pendFlag);

  // R12
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> ($rose(pendFlag) || $rose(alarmEn)));
endmodule

bind rtc_seconds rtc_seconds_chk chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
  .countWord(countWord), .runEn(dpCtl.runEn), .commit(dpCtl.commit),
  .alarmEn(dpCtl.alarmArm), .matchHit(matchHit), .pendFlag(pendFlag), .alarmIrq(alarmIrq)
);

// File: tb/rtc_seconds_tb_top.sv
module rtc_seconds_tb_top;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWr = 1'b0;
  logic [7:0] busRdata;
  logic       alarmIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rtc_seconds #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRdata(busRdata), .alarmIrq(alarmIrq)
  );

  // behavioural reference state
  logic [31:0] mCount, mShadow, mAlarm;
  logic        mRun, mArm, mPend;
  int          mPre;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [3:0] a);
    case (a)
      4'h0: return {mRun, 7'b0};
      4'h1: return {mArm, 7'b0};
      4'h2: return {7'b0, mPend};
      4'h8, 4'h9, 4'hA, 4'hB: return mCount[8*int'(a[1:0]) +: 8];
      4'hC, 4'hD, 4'hE, 4'hF: return mAlarm[8*int'(a[1:0]) +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagFor(input logic [3:0] a);
    if (a == 4'h2) return "R10";
    if (a < 4'h2)  return "R9";
    if (a < 4'h8)  return "R4";
    if (a < 4'hC)  return "R2";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = '0; mShadow = '0; mAlarm = '0;
      mRun = 1'b0; mArm = 1'b0; mPend = 1'b0; mPre = 0;
    end else begin
      bit tick, hit;
      logic [31:0] nxt;
      tick = mRun && (mPre == DIV - 1);
      hit  = tick && mArm && ((mCount + 32'd1) == mAlarm);
      nxt  = mCount;
      if (busWr && busAddr == 4'h4 && !mRun) nxt = {mShadow[31:8], busWdata};
      else if (tick) nxt = mCount + 32'd1;
      mPre = (!mRun || tick) ? 0 : mPre + 1;
      if (hit) mPend = 1'b1;
      else if (busWr && busAddr == 4'h2 && !busWdata[0]) mPend = 1'b0;
      if (busWr) begin
        if (busAddr == 4'h0) mRun = busWdata[7];
        if (busAddr == 4'h1) mArm = busWdata[7];
        if (busAddr >= 4'h5 && busAddr <= 4'h7) mShadow[8*int'(busAddr[1:0]) +: 8] = busWdata;
        if (busAddr >= 4'hC) mAlarm[8*int'(busAddr[1:0]) +: 8] = busWdata;
      end
      mCount = nxt;
    end
  end

  // compare against the reference every cycle, away from the clock edge
  always @(negedge clk) begin
    #5;
    if (rstN && !done) begin
      check(tagFor(busAddr), {24'h0, busRdata}, {24'h0, modelRead(busAddr)});
      check("R12", {31'h0, alarmIrq}, {31'h0, mPend && mArm});
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b0;
    #5;
    d = busRdata;
  endtask

  task automatic readTime(output logic [31:0] w);
    logic [7:0] b, again;
    for (int i = 0; i < 4; i++) begin
      busRead(4'(8 + i), b);
      w[8*i +: 8] = b;
    end
    busRead(4'h8, again);
    if (again < w[7:0]) begin
      for (int i = 0; i < 4; i++) begin
        busRead(4'(8 + i), b);
        w[8*i +: 8] = b;
      end
    end
  endtask

  task automatic setTime(input logic [31:0] v);
    busWrite(4'h1, 8'h00);
    busWrite(4'h0, 8'h00);
    busWrite(4'h4, 8'h00);
    busWrite(4'h5, v[15:8]);
    busWrite(4'h6, v[23:16]);
    busWrite(4'h7, v[31:24]);
    busWrite(4'h4, v[7:0]);
  endtask

  task automatic setAlarm(input logic [31:0] v);
    for (int i = 0; i < 4; i++) busWrite(4'(12 + i), v[8*i +: 8]);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readTime(w);               check("R1", w, 32'h0);
    busRead(4'h0, b);          check("R1", {24'h0, b}, 32'h0);
    busRead(4'h2, b);          check("R1", {24'h0, b}, 32'h0);
    check("R1", {31'h0, alarmIrq}, 32'h0);

    // R4 shadow only, R5 commit
    busWrite(4'h5, 8'hAA); busWrite(4'h6, 8'hBB); busWrite(4'h7, 8'hCC);
    readTime(w);               check("R4", w, 32'h0);
    busRead(4'h6, b);          check("R4", {24'h0, b}, 32'h0);
    setTime(32'h12345678);
    readTime(w);               check("R5", w, 32'h12345678);

    // R2 running, R6 low-byte write ignored while running
    busWrite(4'h0, 8'h80);
    busRead(4'h0, b);          check("R9", {24'h0, b}, 32'h80);
    repeat (3 * DIV) @(negedge clk);
    busWrite(4'h4, 8'h00);
    busWrite(4'h0, 8'h00);
    readTime(w);               check("R6", w, mCount);
    check("R2", {31'h0, (w > 32'h12345678)}, 32'h1);

    // R7 carry-aware read while running
    busWrite(4'h0, 8'h80);
    repeat (7) begin
      readTime(w);
      check("R7", {31'h0, (mCount - w) <= 32'd1}, 32'h1);
    end

    // R3 wrap
    setTime(32'hFFFFFFFF);
    busWrite(4'h0, 8'h80);
    repeat (DIV) @(negedge clk);
    busWrite(4'h0, 8'h00);
    readTime(w);               check("R3", w, 32'h0);

    // R10 no set when unarmed
    setTime(32'd100);
    setAlarm(32'd101);
    busWrite(4'h0, 8'h80);
    repeat (3 * DIV) @(negedge clk);
    busRead(4'h2, b);          check("R10", {24'h0, b}, 32'h0);

    // R8 alarm readback, R10 set when armed
    busWrite(4'h0, 8'h00);
    setTime(32'd200);
    setAlarm(32'hA1B2_00CB);
    busRead(4'hD, b);          check("R8", {24'h0, b}, 32'h00);
    busRead(4'hF, b);          check("R8", {24'h0, b}, 32'hA1);
    setAlarm(32'd203);
    busWrite(4'h1, 8'h80);
    busRead(4'h1, b);          check("R9", {24'h0, b}, 32'h80);
    busWrite(4'h0, 8'h80);
    for (int k = 0; k < 6 * DIV && !alarmIrq; k++) @(negedge clk);
    check("R12", {31'h0, alarmIrq}, 32'h1);
    busRead(4'h2, b);          check("R10", {24'h0, b}, 32'h1);

    // R11 clear semantics
    busWrite(4'h2, 8'h01);
    busRead(4'h2, b);          check("R11", {24'h0, b}, 32'h1);
    busWrite(4'h2, 8'h00);
    busRead(4'h2, b);          check("R11", {24'h0, b}, 32'h0);
    check("R12", {31'h0, alarmIrq}, 32'h0);

    // R12 disarm drops the line while pending stays
    busWrite(4'h0, 8'h00);
    setTime(32'd300);
    setAlarm(32'd302);
    busWrite(4'h1, 8'h80);
    busWrite(4'h0, 8'h80);
    for (int k = 0; k < 6 * DIV && !alarmIrq; k++) @(negedge clk);
    check("R12", {31'h0, alarmIrq}, 32'h1);
    busWrite(4'h1, 8'h00);
    check("R12", {31'h0, alarmIrq}, 32'h0);
    busRead(4'h2, b);          check("R10", {24'h0, b}, 32'h1);
    repeat (2 * DIV) @(negedge clk);

    finishRun();
  end
endmodule